// File: doc/BRIEF.md
# Dual-Prescaler Watchdog Interval Timer

An 8-bit up-counting timer that serves either as a periodic interval timer or as a watchdog. The count pulses come from one of two free-running prescaler chains. One runs on every cycle of the fast system clock. The other advances only on a sub-clock enable input. Each chain offers eight division taps. A single 8-bit control/status register selects the chain, the tap, the operating mode, the watchdog action and the enable. The same register holds a sticky overflow flag.

Software writes the register with a 16-bit word. The upper byte of that word must carry a fixed key, or the write is dropped. Reads return the 8-bit register directly. A read strobe tells the block that software has seen the flag. The flag can be cleared only by writing 0 to it after a read that returned it as 1, or by disabling the timer. In interval mode an overflow raises a level interrupt that stays high while the flag is set. In watchdog mode an overflow produces a one-cycle NMI request or a one-cycle internal reset request.

Top module: `wdt_dual_prescaler`

## Requirements
- R1: After rst_ni is asserted, rdata_o reads 0x00 and irq_o, nmi_o and rst_req_o are low.
- R2: A write whose wdata_i[15:8] is not 0xA5 leaves every control field unchanged. A write with 0xA5 in wdata_i[15:8] loads bits 6..0 from wdata_i[6:0].
- R3: Register bit positions: bit 7 is the overflow flag, bit 6 is the mode (1 = watchdog), bit 5 is the enable, bit 4 is the source (1 = sub-clock chain), bit 3 selects the watchdog action (1 = reset, 0 = NMI), and bits 2..0 are the tap code.
- R4: With source 0, tap codes 0..7 divide the system clock by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. Consecutive overflows are 256 times that divisor apart.
- R5: With source 1, tap code c divides the sub-clock enable by 2^(c+1). Consecutive overflows are 256·2^(c+1) sub-clock enables apart.
- R6: While the enable is 0, the counter is held at 0x00 and no overflow occurs. An accepted write with enable 0 clears the flag. After the enable is set, counting restarts from 0x00.
- R7: The 0xFF to 0x00 wrap sets the flag. In interval mode, irq_o equals the flag.
- R8: An accepted write with bit 7 = 0 clears the flag only if a read strobe was given while the flag read 1 and no accepted write has come since. A written 1 never sets the flag.
- R9: In watchdog mode with action 0, each overflow sets the flag and produces a one-cycle nmi_o pulse in the cycle after the wrap. irq_o stays low.
- R10: In watchdog mode with action 1, each overflow produces a one-cycle rst_req_o pulse in the cycle after the wrap, and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_en_i | input | 1 | One-cycle enable per sub-clock period |
| rd_i | input | 1 | Read strobe for the control/status register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write word: key in [15:8], register value in [7:0] |
| rdata_o | output | 8 | Control/status register value |
| irq_o | output | 1 | Interval interrupt level |
| nmi_o | output | 1 | NMI request pulse |
| rst_req_o | output | 1 | Internal reset request pulse |

## Verification
The assertions check four things on every cycle. No two prescaler taps fire together. The counter changes only on a tap pulse or when it is forced to zero. The flag rises only on an overflow, and a key mismatch leaves the control fields untouched. The NMI and reset pulses last one cycle, never coincide, and a write-driven flag clear always follows an armed read. Only the bench scenarios can show the absolute overflow period for each tap and source. They also show the restart from zero after re-enabling and the whole read-then-write-0 clearing sequence, as seen at the ports.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] WR_KEY    = 8'hA5;
  localparam int         SYS_PRE_W = 17;
  localparam int         SUB_PRE_W = 8;
  localparam int         CNT_W     = 8;

  typedef struct packed {
    logic       ovf;
    logic       wd;
    logic       en;
    logic       sub;
    logic       rst_sel;
    logic [2:0] cks;
  } csr_t;

  // system chain: tap bit k divides by 2^(k+1)
  function automatic logic [4:0] sys_tap(input logic [2:0] sel);
    case (sel)
      3'd0:    sys_tap = 5'd0;
      3'd1:    sys_tap = 5'd5;
      3'd2:    sys_tap = 5'd6;
      3'd3:    sys_tap = 5'd8;
      3'd4:    sys_tap = 5'd10;
      3'd5:    sys_tap = 5'd12;
      3'd6:    sys_tap = 5'd14;
      default: sys_tap = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  // bit k rises on this increment when lower bits are all ones and bit k is 0
  for (genvar k = 0; k < W; k++) begin : g_tap
    if (k == 0) begin : g_lsb
      assign tick_o[k] = inc_i & ~cnt_q[0];
    end else begin : g_up
      assign tick_o[k] = inc_i & (&cnt_q[k-1:0]) & ~cnt_q[k];
    end
  end

  AST_ONE_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tick_o)); // R4
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic wd_i,
  input  logic rst_sel_i,
  output logic ovf_o,
  output logic nmi_o,
  output logic rst_req_o
);
  logic [CW-1:0] cnt_q;

  assign ovf_o = run_i & tick_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      nmi_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      if (!run_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
      nmi_o     <= ovf_o & wd_i & ~rst_sel_i;
      rst_req_o <= ovf_o & wd_i & rst_sel_i;
    end
  end

  AST_COUNT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> ($past(tick_i) || cnt_q == '0)); // R4
  AST_NMI_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o); // R9
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R10
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nmi_o && rst_req_o)); // R9
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl import wdt_pkg::*; #(
  parameter logic [7:0] KEY = WR_KEY
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  input  logic        ovf_evt_i,
  output csr_t        csr_o
);
  csr_t csr_q;
  logic armed_q;
  logic wr_ok, wd_rst_evt, wr_clr;

  assign wr_ok      = wr_i && (wdata_i[15:8] == KEY);
  assign wd_rst_evt = ovf_evt_i & csr_q.wd & csr_q.rst_sel;
  assign wr_clr     = wr_ok && (!wdata_i[5] || (armed_q && !wdata_i[7]));
  assign csr_o      = csr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        csr_q.wd      <= wdata_i[6];
        csr_q.en      <= wdata_i[5];
        csr_q.sub     <= wdata_i[4];
        csr_q.rst_sel <= wdata_i[3];
        csr_q.cks     <= wdata_i[2:0];
        armed_q       <= 1'b0;
      end else if (rd_i && csr_q.ovf) begin
        armed_q <= 1'b1;
      end
      // the generated reset also clears the flag
      if (wd_rst_evt)     csr_q.ovf <= 1'b0;
      else if (ovf_evt_i) csr_q.ovf <= 1'b1;
      else if (wr_clr)    csr_q.ovf <= 1'b0;
    end
  end

  AST_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csr_q.ovf) |-> $past(ovf_evt_i)); // R7
  AST_KEY_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[15:8] != KEY) |=> (csr_q[6:0] == $past(csr_q[6:0]))); // R2
  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(csr_q.ovf) && $past(wr_i && wdata_i[5] && !ovf_evt_i)) |-> $past(armed_q)); // R8
endmodule

// File: rtl/wdt_dual_prescaler.sv
module wdt_dual_prescaler import wdt_pkg::*; #(
  parameter logic [7:0] KEY = WR_KEY
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sub_en_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic        nmi_o,
  output logic        rst_req_o
);
  csr_t                 csr;
  logic [SYS_PRE_W-1:0] sys_ticks;
  logic [SUB_PRE_W-1:0] sub_ticks;
  logic                 tick, ovf_evt;

  wdt_prescaler #(.W(SYS_PRE_W)) u_sys_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(1'b1), .tick_o(sys_ticks)
  );

  wdt_prescaler #(.W(SUB_PRE_W)) u_sub_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sub_en_i), .tick_o(sub_ticks)
  );

  assign tick = csr.sub ? sub_ticks[csr.cks] : sys_ticks[sys_tap(csr.cks)];

  wdt_count #(.CW(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(csr.en), .tick_i(tick),
    .wd_i(csr.wd), .rst_sel_i(csr.rst_sel), .ovf_o(ovf_evt),
    .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  wdt_ctrl #(.KEY(KEY)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .ovf_evt_i(ovf_evt), .csr_o(csr)
  );

  assign rdata_o = csr;
  assign irq_o   = csr.ovf & ~csr.wd;

  AST_IRQ_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr.wd |-> !irq_o); // R9
endmodule

// File: tb/sim_wdt_dual_prescaler.sv
`timescale 1ns/1ps
module sim_wdt_dual_prescaler;
  logic        clk = 1'b0, rst_n = 1'b0, sub_en = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        irq, nmi, rreq;
  int          cyc = 0, n_chk = 0, n_bad = 0;

  wdt_dual_prescaler u0 (
    .clk_i(clk), .rst_ni(rst_n), .sub_en_i(sub_en), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .nmi_o(nmi), .rst_req_o(rreq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk);
      sub_en = ((cyc % 4) == 0);
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [15:0] w);
    wdata = w; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg;
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_on(input int which, input int limit, output int t, output bit seen);
    seen = 1'b0; t = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((which == 0 && irq) || (which == 1 && nmi) || (which == 2 && rreq)) begin
        seen = 1'b1; t = cyc;
        break;
      end
    end
  endtask

  task automatic t_reset;
    chk(rdata == 8'h00, "R1 register after reset", int'(rdata), 0);
    chk({irq, nmi, rreq} == 3'b000, "R1 outputs after reset", int'({irq, nmi, rreq}), 0);
  endtask

  task automatic t_key;
    bit s; int t;
    wr_word(16'h5A25);
    chk(rdata == 8'h00, "R2 wrong key ignored", int'(rdata), 0);
    wait_on(0, 700, t, s);
    chk(!s, "R2 wrong key did not enable", int'(s), 0);
    wr_word(16'hA55B);
    chk(rdata == 8'h5B, "R3 field load", int'(rdata), 'h5B);
    wr_word(16'hA5DB);
    chk(rdata == 8'h5B, "R8 written one does not set flag", int'(rdata), 'h5B);
    wr_word(16'hA500);
  endtask

  task automatic t_period(input bit src, input logic [2:0] code, input int exp, input string tag);
    bit s; int t1, t2;
    logic [15:0] w;
    w = {8'hA5, 1'b0, 1'b0, 1'b1, src, 1'b0, code};
    wr_word(16'hA500);
    wr_word(w);
    wait_on(0, 2 * exp + 64, t1, s);
    chk(s, {tag, " first overflow seen"}, int'(s), 1);
    chk(rdata[7] == 1'b1, "R7 flag set on wrap", int'(rdata[7]), 1);
    wr_word(w);
    chk(rdata[7] == 1'b1, "R8 clear without read ignored", int'(rdata[7]), 1);
    rd_reg();
    wr_word(w);
    chk(rdata[7] == 1'b0, "R8 clear after read", int'(rdata[7]), 0);
    chk(irq == 1'b0, "R7 irq follows flag", int'(irq), 0);
    wait_on(0, exp + 64, t2, s);
    chk(s && (t2 - t1 == exp), tag, t2 - t1, exp);
  endtask

  task automatic t_disable;
    bit s; int t, t0;
    wr_word(16'hA500);
    wr_word(16'hA520);
    wait_on(0, 1200, t, s);
    chk(s, "R6 overflow before disable", int'(s), 1);
    wr_word(16'hA500);
    chk(rdata == 8'h00 && !irq, "R6 disable clears flag", int'(rdata), 0);
    wait_on(0, 2000, t, s);
    chk(!s, "R6 no overflow while disabled", int'(s), 0);
    t0 = cyc;
    wr_word(16'hA520);
    wait_on(0, 1200, t, s);
    chk(s && (t - t0 >= 505) && (t - t0 <= 520), "R6 restart from zero", t - t0, 512);
  endtask

  task automatic t_nmi;
    bit s; int t1, t2;
    wr_word(16'hA500);
    wr_word(16'hA560);
    wait_on(1, 1200, t1, s);
    chk(s && rdata[7], "R9 NMI with flag set", int'(rdata), 'hE0);
    chk(!irq && !rreq, "R9 no irq or reset", int'({irq, rreq}), 0);
    @(negedge clk);
    chk(!nmi, "R9 NMI one cycle", int'(nmi), 0);
    wait_on(1, 700, t2, s);
    chk(s && (t2 - t1 == 512), "R9 NMI repeat period", t2 - t1, 512);
  endtask

  task automatic t_wdrst;
    bit s; int t1, t2;
    wr_word(16'hA500);
    wr_word(16'hA568);
    wait_on(2, 1200, t1, s);
    chk(s && !rdata[7], "R10 reset keeps flag clear", int'(rdata), 'h68);
    chk(!nmi && !irq, "R10 no NMI or irq", int'({nmi, irq}), 0);
    @(negedge clk);
    chk(!rreq && !rdata[7], "R10 reset one cycle", int'(rreq), 0);
    wait_on(2, 700, t2, s);
    chk(s && (t2 - t1 == 512), "R10 reset repeat period", t2 - t1, 512);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key();
    t_period(1'b0, 3'd0, 512, "R4 system tap 0");
    t_period(1'b0, 3'd1, 16384, "R4 system tap 1");
    t_period(1'b1, 3'd0, 2048, "R5 sub tap 0");
    t_period(1'b1, 3'd2, 8192, "R5 sub tap 2");
    t_disable();
    t_nmi();
    t_wdrst();
    summary();
    $finish;
  end
endmodule